// File: doc/BRIEF.md
# Pin I/O Controller with Set/Clear Registers

This block is a general-purpose pin controller that sits on an APB slave port. For each of its pins it holds an output level, a drive enable and an interrupt setup. Software never has to read a register, change one bit and write it back. Each setting has one address where ones written turn bits on and another address where ones written turn bits off. Bits written as zero are left alone.

Pad inputs pass through a two-flop synchronizer before software can read them or the interrupt logic can see them. A loopback control bit swaps the pad inputs for the block's own output levels, so firmware can test the input path and the interrupt path with no external wiring. Each pin can raise an interrupt on a level or on a latched edge, with a chosen polarity or on either edge. The enabled pin interrupts are ORed onto one interrupt line. Reads complete in the access phase with no wait states.

Top module: `gpio_apb_ctrl`

## Requirements
- R1: After reset every pin is an input (`gpio_oe` = 0), `gpio_out` = 0 and `irq` = 0. Interrupt enables, edge selects and any-edge selects read back as 0, and polarity reads back as all ones (active high / rising).
- R2: Writing ones at offset 0x00 sets those bits of `gpio_out`. Writing ones at offset 0x04 clears them. Zero bits in either write leave the output unchanged.
- R3: Writing ones at 0x08 sets the matching `gpio_oe` bits (output). Writing ones at 0x0C clears them (input). Both offsets read back the current direction.
- R4: Each interrupt setting has a set/clear offset pair, and both offsets of a pair read the current value: enable at 0x10/0x14, edge select at 0x18/0x1C (bit = 1 means edge-sensitive), polarity at 0x20/0x24 (bit = 1 means high or rising), any-edge at 0x28/0x2C.
- R5: A read at 0x00 returns the synchronized input levels. A pad change made before clock edge k is visible from edge k+1 on, and not before it.
- R6: Bit 0 of the control register at 0x34 selects loopback when set. In loopback each pin's synchronizer samples that pin's `gpio_out` bit in place of `gpio_in`. The register reads back its value.
- R7: A pin in level mode reports status 1 while its synchronized input equals its polarity bit.
- R8: A pin in edge mode latches status on a rising edge (polarity 1) or a falling edge (polarity 0). With any-edge set, it latches on both edges. The status stays set after the input returns.
- R9: Writing ones at 0x30 clears the latched edge status of those pins, and zero bits have no effect. A read at 0x30 returns 0.
- R10: A read at 0x04 returns the per-pin status whether the pin is enabled or not. `irq` is 1 exactly when some pin has status 1 and its enable bit set.
- R11: Reads at unmapped or misaligned offsets (0x38 to 0x3F) return 0, and writes there change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and block clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when high |
| paddr | input | ADDR_W | Byte address within the window |
| pwdata | input | DATA_W | Write data |
| prdata | output | DATA_W | Read data, valid in the access phase |
| gpio_in | input | N_PINS | Raw pad input levels |
| gpio_out | output | N_PINS | Output level per pin |
| gpio_oe | output | N_PINS | Drive enable per pin, 1 = output |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach is an edge that arrives at the detector in a known cycle while the pin is set up in a given polarity and any-edge mode, and then checking that it stays latched until a masked clear. The bench drives pad edges at negedges and waits more than the synchronizer depth before each status read. It then clears with a zero mask, then a one mask, so latching and selective clearing are both seen at the bus. Loopback is checked by setting outputs through the set/clear registers while the pads are held at zero, so any value read back can only come from the internal feedback path.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  // Word indexes inside the register window (byte offset = index * 4)
  localparam int W_STATE_SET   = 0;
  localparam int W_STAT_CLROUT = 1;
  localparam int W_DIR_OUT     = 2;
  localparam int W_DIR_IN      = 3;
  localparam int W_IEN_SET     = 4;
  localparam int W_IEN_CLR     = 5;
  localparam int W_EDGE_SET    = 6;
  localparam int W_EDGE_CLR    = 7;
  localparam int W_POL_SET     = 8;
  localparam int W_POL_CLR     = 9;
  localparam int W_ANY_SET     = 10;
  localparam int W_ANY_CLR     = 11;
  localparam int W_FLAG_CLR    = 12;
  localparam int W_CTRL        = 13;
  localparam int N_WORDS       = 14;

  // Edge event on one pin given current/previous synchronized level
  function automatic logic edge_hit(logic cur, logic prv, logic pol, logic any);
    logic rise;
    logic fall;
    rise = cur & ~prv;
    fall = ~cur & prv;
    if (any) return rise | fall;
    return pol ? rise : fall;
  endfunction

  // Level interrupt condition on one pin
  function automatic logic level_hit(logic cur, logic pol);
    return cur == pol;
  endfunction

endpackage

// File: rtl/gpio_setclr_reg.sv
module gpio_setclr_reg #(
  parameter int          N_PINS = 32,
  parameter logic [31:0] RST_VAL = 32'h0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic              clr_en,
  input  logic [N_PINS-1:0] wmask,
  output logic [N_PINS-1:0] q
);

  logic [N_PINS-1:0] set_bits;
  logic [N_PINS-1:0] clr_bits;

  assign set_bits = set_en ? wmask : '0;
  assign clr_bits = clr_en ? wmask : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RST_VAL[N_PINS-1:0];
    else        q <= (q | set_bits) & ~clr_bits;
  end

  assert_set_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> ((q & $past(wmask)) == $past(wmask)));

  assert_clr_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> ((q & $past(wmask)) == '0));

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_en && !clr_en) |=> $stable(q));

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int N_PINS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] pad_in,
  input  logic [N_PINS-1:0] loop_val,
  input  logic              loop_en,
  output logic [N_PINS-1:0] sync_q
);

  logic [N_PINS-1:0] src;
  logic [N_PINS-1:0] stage1;
  logic [N_PINS-1:0] stage2;

  assign src = loop_en ? loop_val : pad_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= src;
      stage2 <= stage1;
    end
  end

  assign sync_q = stage2;

  // Edge counter since reset so the latency check never looks before it
  logic [1:0] armed_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 armed_cnt <= 2'd0;
    else if (armed_cnt != 2'd3) armed_cnt <= armed_cnt + 2'd1;
  end

  assert_two_stage_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_cnt >= 2'd2) |-> (sync_q == $past(src, 2)));

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int N_PINS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] sync_in,
  input  logic [N_PINS-1:0] ien,
  input  logic [N_PINS-1:0] edge_mode,
  input  logic [N_PINS-1:0] pol,
  input  logic [N_PINS-1:0] any_edge,
  input  logic [N_PINS-1:0] flag_clr,
  output logic [N_PINS-1:0] status,
  output logic              irq
);
  import gpio_pkg::*;

  logic [N_PINS-1:0] prev_q;
  logic [N_PINS-1:0] edge_ev;
  logic [N_PINS-1:0] lvl_ev;
  logic [N_PINS-1:0] flag_q;
  logic [N_PINS-1:0] pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= sync_in;
  end

  for (genvar p = 0; p < N_PINS; p++) begin : g_pin
    assign edge_ev[p] = edge_hit(sync_in[p], prev_q[p], pol[p], any_edge[p]);
    assign lvl_ev[p]  = level_hit(sync_in[p], pol[p]);

    // A new event wins over a clear arriving in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             flag_q[p] <= 1'b0;
      else if (!edge_mode[p]) flag_q[p] <= 1'b0;
      else if (edge_ev[p])    flag_q[p] <= 1'b1;
      else if (flag_clr[p])   flag_q[p] <= 1'b0;
    end

    assign status[p] = edge_mode[p] ? flag_q[p] : lvl_ev[p];
  end

  assign pending = status & ien;
  assign irq     = |pending;

  assert_no_irq_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ien == '0) |-> !irq);

  assert_flag_cleared_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag_clr & edge_ev) == '0 && flag_clr != '0) |=> ((flag_q & $past(flag_clr)) == '0));

  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr == '0 && $stable(edge_mode)) |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

endmodule

// File: rtl/gpio_apb_regs.sv
module gpio_apb_regs #(
  parameter int N_PINS = 32,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  input  logic [N_PINS-1:0] state_in,
  input  logic [N_PINS-1:0] irq_stat,
  output logic [N_PINS-1:0] out_q,
  output logic [N_PINS-1:0] oe_q,
  output logic [N_PINS-1:0] ien_q,
  output logic [N_PINS-1:0] edge_q,
  output logic [N_PINS-1:0] pol_q,
  output logic [N_PINS-1:0] any_q,
  output logic [N_PINS-1:0] flag_clr,
  output logic              loop_q
);
  import gpio_pkg::*;

  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] widx;
  logic              aligned;
  logic              wr_acc;
  logic              rd_acc;
  logic [N_WORDS-1:0] wr_hit;
  logic              addr_mapped;
  logic [N_PINS-1:0] wmask;
  logic [N_PINS-1:0] rd_pins;
  logic [DATA_W-1:0] rd_word;

  assign widx    = paddr[ADDR_W-1:2];
  assign aligned = (paddr[1:0] == 2'b00);
  assign wr_acc  = psel & penable & pwrite;
  assign rd_acc  = psel & ~pwrite;
  assign wmask   = pwdata[N_PINS-1:0];
  assign addr_mapped = aligned && (int'(widx) < N_WORDS);

  for (genvar w = 0; w < N_WORDS; w++) begin : g_hit
    assign wr_hit[w] = wr_acc && aligned && (int'(widx) == w);
  end

  // Paired set/clear storage for every per-pin setting
  gpio_setclr_reg #(.N_PINS(N_PINS), .RST_VAL(32'h0)) u_out (
    .clk(clk), .rst_n(rst_n), .set_en(wr_hit[W_STATE_SET]),
    .clr_en(wr_hit[W_STAT_CLROUT]), .wmask(wmask), .q(out_q));

  gpio_setclr_reg #(.N_PINS(N_PINS), .RST_VAL(32'h0)) u_oe (
    .clk(clk), .rst_n(rst_n), .set_en(wr_hit[W_DIR_OUT]),
    .clr_en(wr_hit[W_DIR_IN]), .wmask(wmask), .q(oe_q));

  gpio_setclr_reg #(.N_PINS(N_PINS), .RST_VAL(32'h0)) u_ien (
    .clk(clk), .rst_n(rst_n), .set_en(wr_hit[W_IEN_SET]),
    .clr_en(wr_hit[W_IEN_CLR]), .wmask(wmask), .q(ien_q));

  gpio_setclr_reg #(.N_PINS(N_PINS), .RST_VAL(32'h0)) u_edge (
    .clk(clk), .rst_n(rst_n), .set_en(wr_hit[W_EDGE_SET]),
    .clr_en(wr_hit[W_EDGE_CLR]), .wmask(wmask), .q(edge_q));

  gpio_setclr_reg #(.N_PINS(N_PINS), .RST_VAL(32'hFFFF_FFFF)) u_pol (
    .clk(clk), .rst_n(rst_n), .set_en(wr_hit[W_POL_SET]),
    .clr_en(wr_hit[W_POL_CLR]), .wmask(wmask), .q(pol_q));

  gpio_setclr_reg #(.N_PINS(N_PINS), .RST_VAL(32'h0)) u_any (
    .clk(clk), .rst_n(rst_n), .set_en(wr_hit[W_ANY_SET]),
    .clr_en(wr_hit[W_ANY_CLR]), .wmask(wmask), .q(any_q));

  assign flag_clr = wr_hit[W_FLAG_CLR] ? wmask : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              loop_q <= 1'b0;
    else if (wr_hit[W_CTRL]) loop_q <= pwdata[0];
  end

  // Read mux: pin-wide value per word, control and clear words handled apart
  always_comb begin
    rd_pins = '0;
    case (int'(widx))
      W_STATE_SET:              rd_pins = state_in;
      W_STAT_CLROUT:            rd_pins = irq_stat;
      W_DIR_OUT, W_DIR_IN:      rd_pins = oe_q;
      W_IEN_SET, W_IEN_CLR:     rd_pins = ien_q;
      W_EDGE_SET, W_EDGE_CLR:   rd_pins = edge_q;
      W_POL_SET, W_POL_CLR:     rd_pins = pol_q;
      W_ANY_SET, W_ANY_CLR:     rd_pins = any_q;
      default:                  rd_pins = '0;
    endcase
  end

  always_comb begin
    rd_word = '0;
    if (int'(widx) == W_CTRL) rd_word[0] = loop_q;
    else                      rd_word[N_PINS-1:0] = rd_pins;
  end

  assign prdata = (rd_acc && addr_mapped) ? rd_word : '0;

  assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && !addr_mapped) |-> (prdata == '0));

  assert_single_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_hit));

  assert_loop_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit[W_CTRL] |=> (loop_q == $past(pwdata[0])));

endmodule

// File: rtl/gpio_apb_ctrl.sv
module gpio_apb_ctrl #(
  parameter int N_PINS = 32,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  input  logic [N_PINS-1:0] gpio_in,
  output logic [N_PINS-1:0] gpio_out,
  output logic [N_PINS-1:0] gpio_oe,
  output logic              irq
);

  logic [N_PINS-1:0] sync_lvl;
  logic [N_PINS-1:0] stat;
  logic [N_PINS-1:0] out_q;
  logic [N_PINS-1:0] oe_q;
  logic [N_PINS-1:0] ien_q;
  logic [N_PINS-1:0] edge_q;
  logic [N_PINS-1:0] pol_q;
  logic [N_PINS-1:0] any_q;
  logic [N_PINS-1:0] flag_clr;
  logic              loop_q;

  gpio_apb_regs #(.N_PINS(N_PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(pclk), .rst_n(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .state_in(sync_lvl), .irq_stat(stat), .out_q(out_q), .oe_q(oe_q),
    .ien_q(ien_q), .edge_q(edge_q), .pol_q(pol_q), .any_q(any_q),
    .flag_clr(flag_clr), .loop_q(loop_q));

  gpio_in_sync #(.N_PINS(N_PINS)) u_sync (
    .clk(pclk), .rst_n(presetn), .pad_in(gpio_in), .loop_val(out_q),
    .loop_en(loop_q), .sync_q(sync_lvl));

  gpio_irq_detect #(.N_PINS(N_PINS)) u_irq (
    .clk(pclk), .rst_n(presetn), .sync_in(sync_lvl), .ien(ien_q),
    .edge_mode(edge_q), .pol(pol_q), .any_edge(any_q), .flag_clr(flag_clr),
    .status(stat), .irq(irq));

  assign gpio_out = out_q;
  assign gpio_oe  = oe_q;

  assert_reset_inputs_R1: assert property (@(posedge pclk) disable iff (!presetn)
    $rose(presetn) |-> (gpio_oe == '0));

endmodule

// File: tb/test_gpio_apb_ctrl.sv
`timescale 1ns/1ps
module test_gpio_apb_ctrl;

  logic        pclk = 1'b0;
  logic        presetn = 1'b0;
  logic        psel = 1'b0;
  logic        penable = 1'b0;
  logic        pwrite = 1'b0;
  logic [5:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic [31:0] gpio_in = '0;
  logic [31:0] gpio_out;
  logic [31:0] gpio_oe;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 pclk = ~pclk;

  gpio_apb_ctrl i_gpio_apb_ctrl (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .gpio_in(gpio_in), .gpio_out(gpio_out), .gpio_oe(gpio_oe), .irq(irq));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge pclk);
  endtask

  task automatic apb_write(input logic [5:0] a, input logic [31:0] d);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d;
    @(negedge pclk);
    penable = 1'b1;
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apb_read(input logic [5:0] a, output logic [31:0] d);
    psel = 1'b1; pwrite = 1'b0; paddr = a;
    @(negedge pclk);
    penable = 1'b1;
    d = prdata;
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] r;
    check("R1 oe", gpio_oe, 32'h0);
    check("R1 out", gpio_out, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
    apb_read(6'h20, r); check("R1 pol", r, 32'hFFFF_FFFF);
    apb_read(6'h18, r); check("R1 edge", r, 32'h0);
    apb_read(6'h14, r); check("R1 ien", r, 32'h0);
    apb_read(6'h2C, r); check("R1 any", r, 32'h0);
  endtask

  task automatic t_outputs();
    apb_write(6'h00, 32'hA5A5_0F0F);
    check("R2 set", gpio_out, 32'hA5A5_0F0F);
    apb_write(6'h04, 32'h0000_000F);
    check("R2 clear", gpio_out, 32'hA5A5_0F00);
    apb_write(6'h00, 32'h0);
    check("R2 zero set", gpio_out, 32'hA5A5_0F00);
    apb_write(6'h04, 32'h0);
    check("R2 zero clear", gpio_out, 32'hA5A5_0F00);
  endtask

  task automatic t_dir();
    logic [31:0] r;
    apb_write(6'h08, 32'hFFFF_0000);
    check("R3 dir out", gpio_oe, 32'hFFFF_0000);
    apb_write(6'h0C, 32'h0F00_0000);
    check("R3 dir in", gpio_oe, 32'hF0FF_0000);
    apb_read(6'h0C, r); check("R3 read in", r, 32'hF0FF_0000);
    apb_read(6'h08, r); check("R3 read out", r, 32'hF0FF_0000);
  endtask

  task automatic t_config();
    logic [31:0] r;
    apb_write(6'h10, 32'h0000_00F0);
    apb_read(6'h14, r); check("R4 ien set", r, 32'h0000_00F0);
    apb_write(6'h14, 32'h0000_0030);
    apb_read(6'h10, r); check("R4 ien clr", r, 32'h0000_00C0);
    apb_write(6'h28, 32'h8000_0001);
    apb_read(6'h2C, r); check("R4 any set", r, 32'h8000_0001);
    apb_write(6'h2C, 32'hFFFF_FFFF);
    apb_read(6'h28, r); check("R4 any clr", r, 32'h0);
    apb_write(6'h24, 32'h0000_FFFF);
    apb_read(6'h20, r); check("R4 pol clr", r, 32'hFFFF_0000);
    apb_write(6'h20, 32'h0000_FFFF);
    apb_read(6'h24, r); check("R4 pol set", r, 32'hFFFF_FFFF);
    apb_write(6'h14, 32'hFFFF_FFFF);
  endtask

  task automatic t_sync();
    logic [31:0] r;
    gpio_in = 32'h1234_5678;
    apb_read(6'h00, r); check("R5 before two edges", r, 32'h0);
    apb_read(6'h00, r); check("R5 after two edges", r, 32'h1234_5678);
    gpio_in = 32'h0;
    wait_clk(3);
    apb_read(6'h00, r); check("R5 back low", r, 32'h0);
  endtask

  task automatic t_loopback();
    logic [31:0] r;
    apb_write(6'h34, 32'h1);
    apb_read(6'h34, r); check("R6 ctrl read", r, 32'h1);
    wait_clk(3);
    apb_read(6'h00, r); check("R6 loop state", r, 32'hA5A5_0F00);
    apb_write(6'h04, 32'hFFFF_FFFF);
    apb_write(6'h00, 32'h0000_0042);
    wait_clk(3);
    apb_read(6'h00, r); check("R6 loop follows", r, 32'h0000_0042);
    apb_write(6'h34, 32'h0);
    wait_clk(3);
    apb_read(6'h00, r); check("R6 pad again", r, 32'h0);
  endtask

  task automatic t_level();
    logic [31:0] r;
    apb_write(6'h10, 32'hFFFF_FFFF);
    gpio_in = 32'h0000_0001;
    wait_clk(3);
    apb_read(6'h04, r); check("R7 level high", r, 32'h0000_0001);
    check("R10 irq on", {31'b0, irq}, 32'h1);
    apb_write(6'h24, 32'hFFFF_FFFF);
    wait_clk(1);
    apb_read(6'h04, r); check("R7 level low", r, 32'hFFFF_FFFE);
    apb_write(6'h14, 32'hFFFF_FFFF);
    check("R10 irq masked", {31'b0, irq}, 32'h0);
    apb_read(6'h04, r); check("R10 raw status", r, 32'hFFFF_FFFE);
    apb_write(6'h20, 32'hFFFF_FFFF);
    gpio_in = 32'h0;
    wait_clk(3);
  endtask

  task automatic t_edge();
    logic [31:0] r;
    apb_write(6'h18, 32'h0000_0003);
    apb_write(6'h10, 32'h0000_0001);
    apb_read(6'h1C, r); check("R4 edge read", r, 32'h0000_0003);
    gpio_in = 32'h0000_0001;
    wait_clk(4);
    apb_read(6'h04, r); check("R8 rise latched", r, 32'h0000_0001);
    gpio_in = 32'h0;
    wait_clk(4);
    apb_read(6'h04, r); check("R8 sticky", r, 32'h0000_0001);
    check("R10 irq edge", {31'b0, irq}, 32'h1);
    apb_write(6'h30, 32'h0);
    apb_read(6'h04, r); check("R9 zero mask", r, 32'h0000_0001);
    apb_write(6'h30, 32'h0000_0001);
    apb_read(6'h04, r); check("R9 cleared", r, 32'h0);
    check("R9 irq low", {31'b0, irq}, 32'h0);
    apb_write(6'h24, 32'h0000_0001);
    gpio_in = 32'h0000_0001;
    wait_clk(4);
    apb_read(6'h04, r); check("R8 rise ignored falling", r, 32'h0);
    gpio_in = 32'h0;
    wait_clk(4);
    apb_read(6'h04, r); check("R8 fall latched", r, 32'h0000_0001);
    apb_write(6'h30, 32'h0000_0001);
    apb_write(6'h28, 32'h0000_0002);
    gpio_in = 32'h0000_0002;
    wait_clk(4);
    apb_read(6'h04, r); check("R8 any rise", r, 32'h0000_0002);
    apb_write(6'h30, 32'h0000_0002);
    gpio_in = 32'h0;
    wait_clk(4);
    apb_read(6'h04, r); check("R8 any fall", r, 32'h0000_0002);
    apb_read(6'h30, r); check("R9 read zero", r, 32'h0);
  endtask

  task automatic t_unmapped();
    logic [31:0] r;
    logic [31:0] out_before;
    logic [31:0] oe_before;
    out_before = gpio_out;
    oe_before = gpio_oe;
    apb_read(6'h38, r); check("R11 read 0x38", r, 32'h0);
    apb_read(6'h3C, r); check("R11 read 0x3C", r, 32'h0);
    apb_write(6'h38, 32'hFFFF_FFFF);
    apb_write(6'h01, 32'hFFFF_FFFF);
    check("R11 out kept", gpio_out, out_before);
    check("R11 oe kept", gpio_oe, oe_before);
    apb_read(6'h10, r); check("R11 ien kept", r, 32'h0000_0001);
  endtask

  initial begin
    wait_clk(3);
    presetn = 1'b1;
    wait_clk(2);
    t_reset();
    t_outputs();
    t_dir();
    t_config();
    t_sync();
    t_loopback();
    t_level();
    t_edge();
    t_unmapped();
    done = 1;
  end

  initial begin
    fork
      wait (done == 1);
      begin
        repeat (20000) @(posedge pclk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule